// File: doc/BRIEF.md
# MDIO Management Register Controller

This block sits behind a small register interface and runs one clause-22 PHY management transaction at a time on the MDC/MDIO pin pair. Software loads a 16-bit data register, then writes a command register that packs the PHY address, the PHY register number, a 3-bit MDC divider select, a write flag and a busy flag. Setting busy launches the serial frame; busy reads back as 1 until the frame has finished on the wire and then clears by itself.

For a write the data register contents go out in the last 16 bit times of the frame. For a read the block releases MDIO at the turnaround, samples the PHY's 16 data bits on rising MDC edges and, when busy drops, leaves the captured value in the data register. MDC is derived from the system clock by a ratio that the divider select picks, and it idles low between transactions.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the data register and the command register read 0, MDC is low and the MDIO output enable is low.
- R2: A command write (addr_i = 1) with bit 0 (busy) set while idle starts a transaction; bit 0 reads 1 until the frame ends and reads 0 again between 64*ratio and 64*ratio+4 clock cycles after the accepting edge.
- R3: A command write while busy reads 1 is ignored: the command fields read back unchanged and the frame in progress is unaffected.
- R4: The MDC period in system clocks is 16, 26, 42, 62 and 102 for select values 0 to 4, and 124 for values 5, 6 and 7.
- R5: A write (bit 1 set) sends 64 bits MSB first: 32 ones, 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then the 16 data bits, with the output enable high for every bit.
- R6: A read (bit 1 clear) sends the same header with opcode 10 and releases the output enable from the first turnaround bit (bit index 46) to the end of the frame.
- R7: During a read the 16 bits presented by the PHY are sampled on rising MDC edges, MSB first, and appear in the data register (addr_i = 0) once busy clears.
- R8: While no transaction is running, MDC stays low and the MDIO output enable stays low.
- R9: The MDIO output changes only while MDC is low, so it is stable across every rising edge.
- R10: A command write with bit 0 clear while idle only updates the stored fields and produces no MDC activity. Command layout: bit 0 busy, bit 1 write, bits 4:2 divider select, bits 10:6 register number, bits 15:11 PHY address, bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write |
| addr_i | input | 1 | 0 selects data register, 1 selects command register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or shift state shows directly on the wire: the captured frame differs from the expected 64-bit pattern, or busy drops outside its narrow window, in the same transaction that carries the fault. A wrong divider state shows as an MDC period other than the selected ratio at the second rising edge. A wrong turnaround decision shows as the output enable held or released at the wrong bit index, and a wrong capture path shows as a data register value that differs from what the PHY model presented, visible on the first read after busy clears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 3;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_IDX    = FRAME_LEN - DATA_W - 2;
  localparam int RD_IDX    = TA_IDX + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int MAX_RATIO = 124;
  localparam int HALF_W    = $clog2(MAX_RATIO / 2 + 1);

  // command register bit positions
  localparam int CMD_BUSY   = 0;
  localparam int CMD_WR     = 1;
  localparam int CMD_SEL_LO = 2;
  localparam int CMD_REG_LO = 6;
  localparam int CMD_PHY_LO = 11;

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regn;
    logic [SEL_W-1:0] sel;
    logic             wr;
  } cmd_t;

  function automatic logic [HALF_W-1:0] half_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    half_ratio = HALF_W'(8);
      3'd1:    half_ratio = HALF_W'(13);
      3'd2:    half_ratio = HALF_W'(21);
      3'd3:    half_ratio = HALF_W'(31);
      3'd4:    half_ratio = HALF_W'(51);
      default: half_ratio = HALF_W'(MAX_RATIO / 2);
    endcase
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(input logic wr,
                                                       input logic [PHY_W-1:0] phy,
                                                       input logic [REG_W-1:0] regn,
                                                       input logic [DATA_W-1:0] data);
    build_frame = {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regn,
                   (wr ? 2'b10 : 2'b00), (wr ? data : {DATA_W{1'b0}})};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              mdc_q;
  logic              wrap;

  assign wrap   = run_i && (cnt_q == half_ratio(sel_i) - HALF_W'(1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 rd_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic                 active_q, rd_q, done_q;
  logic [FRAME_LEN-1:0] shift_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_W-1:0]    rx_q;
  logic                 last_bit;

  assign last_bit  = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign mdio_o    = shift_q[FRAME_LEN-1];
  assign mdio_oe_o = active_q && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));
  assign done_o    = done_q;
  assign rd_data_o = rx_q;
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      done_q   <= 1'b0;
      shift_q  <= '0;
      idx_q    <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        rd_q     <= rd_i;
        shift_q  <= frame_i;
        idx_q    <= '0;
      end else if (active_q) begin
        if (rise_i && rd_q && (idx_q >= IDX_W'(RD_IDX)))
          rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        if (fall_i) begin
          if (last_bit) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  cmd_t              cmd_q, cmd_new;
  logic              busy_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_wr_en, data_wr_en, start;
  logic              rise, fall, seq_done;
  logic [DATA_W-1:0] rx_data;
  logic [IDX_W-1:0]  seq_idx;
  logic              unused_bit5;

  assign unused_bit5 = wdata_i[5];
  assign cmd_wr_en   = req_i && we_i && addr_i;
  assign data_wr_en  = req_i && we_i && !addr_i;
  assign start       = cmd_wr_en && wdata_i[CMD_BUSY] && !busy_q;

  assign cmd_new.phy  = wdata_i[CMD_PHY_LO +: PHY_W];
  assign cmd_new.regn = wdata_i[CMD_REG_LO +: REG_W];
  assign cmd_new.sel  = wdata_i[CMD_SEL_LO +: SEL_W];
  assign cmd_new.wr   = wdata_i[CMD_WR];

  assign rdata_o = addr_i ? {cmd_q.phy, cmd_q.regn, 1'b0, cmd_q.sel, cmd_q.wr, busy_q}
                          : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (data_wr_en) data_q <= wdata_i;
      if (seq_done && !cmd_q.wr) data_q <= rx_data;
      if (cmd_wr_en && !busy_q) cmd_q <= cmd_new;
      if (start) busy_q <= 1'b1;
      else if (seq_done) busy_q <= 1'b0;
    end
  end

  mdio_clk_gen u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .sel_i  (cmd_q.sel),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_i      (!cmd_new.wr),
    .frame_i   (build_frame(cmd_new.wr, cmd_new.phy, cmd_new.regn, data_q)),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (seq_done),
    .rd_data_o (rx_data),
    .idx_o     (seq_idx)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_q,
  input logic                 cmd_wr_en,
  input logic [$bits(cmd_t)-1:0] cmd_bits,
  input logic                 wr_flag,
  input logic [IDX_W-1:0]     seq_idx,
  input logic                 mdc_o,
  input logic                 mdio_o,
  input logic                 mdio_oe_o
);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!mdc_o && !mdio_oe_o));

  p_cmd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_wr_en) |=> $stable(cmd_bits));

  p_ta_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !wr_flag && (seq_idx >= IDX_W'(TA_IDX))) |-> !mdio_oe_o);

  p_drive_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> !mdc_o);

  p_mdc_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> busy_q);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_q    (busy_q),
  .cmd_wr_en (cmd_wr_en),
  .cmd_bits  (cmd_q),
  .wr_flag   (cmd_q.wr),
  .seq_idx   (seq_idx),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0, errors = 0;
  int rise_total = 0, base = 0;
  logic [63:0] cap, oe_cap;
  logic [15:0] phy_val = '0;
  time t0, t1;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model
  always @(posedge mdc) begin
    int idx;
    idx = rise_total - base;
    if (idx < 64) begin
      cap[63-idx]    = mdio_out;
      oe_cap[63-idx] = mdio_oe;
    end
    if (idx == 0) t0 = $time;
    if (idx == 1) t1 = $time;
    rise_total = rise_total + 1;
  end

  always @(negedge mdc) begin
    int idx;
    idx = rise_total - base;
    mdio_in <= (idx >= 48 && idx < 64) ? phy_val[63-idx] : 1'b1;
  end

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic int ratio_of(input logic [2:0] sel);
    case (sel)
      3'd0: return 16; 3'd1: return 26; 3'd2: return 42;
      3'd3: return 62; 3'd4: return 102; default: return 124;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  function automatic logic [15:0] cmd_word(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [2:0] sel, input logic wr, input logic b);
    return {phy, rg, 1'b0, sel, wr, b};
  endfunction

  task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [2:0] sel, input logic [15:0] d, input logic [15:0] pv,
                         input bit poke);
    logic [15:0] v;
    int n, r;
    r = ratio_of(sel);
    phy_val = pv;
    base = rise_total;
    if (wr) bus_write(1'b0, d);
    bus_write(1'b1, cmd_word(phy, rg, sel, wr, 1'b1));
    addr = 1'b1;
    n = 0;
    if (poke) begin
      repeat (100) @(negedge clk);
      n = 101;
      bus_write(1'b1, cmd_word(~phy, ~rg, ~sel, ~wr, 1'b1));
      n = n + 2;
      bus_read(1'b1, v);
      n = n + 1;
      check("R3 cmd unchanged while busy", 64'(v), 64'(cmd_word(phy, rg, sel, wr, 1'b1)));
    end
    #1 check("R2 busy set", 64'(rdata[0]), 64'd1);
    while (rdata[0] === 1'b1 && n < 9000) begin
      @(negedge clk); #1;
      n++;
    end
    checks++;
    if (n < 64*r - 1 || n > 64*r + 4) begin
      errors++;
      $display("FAIL R2 busy duration: actual %0d expected %0d..%0d", n, 64*r - 1, 64*r + 4);
    end
    check("R4 mdc period", 64'((t1 - t0) / 20), 64'(r));
    check("R9/R5 rise count", 64'(rise_total - base), 64'd64);
    if (wr) begin
      check("R5 write frame", cap, exp_frame(1'b1, phy, rg, d));
      check("R5 write oe", oe_cap, {64{1'b1}});
    end else begin
      check("R6 read header", cap[63:18], exp_frame(1'b0, phy, rg, 16'h0) >> 18);
      check("R6 read oe", oe_cap, {{46{1'b1}}, 18'h0});
      bus_read(1'b0, v);
      check("R7 read data", 64'(v), 64'(pv));
    end
    check("R8 idle mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int rt;
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    #1 check("R1 reset mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    bus_read(1'b0, v); check("R1 data reset", 64'(v), 64'h0);
    bus_read(1'b1, v); check("R1 cmd reset", 64'(v), 64'h0);

    // R10: fields only, no activity
    rt = rise_total;
    bus_write(1'b1, cmd_word(5'h15, 5'h0A, 3'd3, 1'b1, 1'b0));
    bus_read(1'b1, v);
    check("R10 cmd fields", 64'(v), 64'(cmd_word(5'h15, 5'h0A, 3'd3, 1'b1, 1'b0)));
    repeat (200) @(negedge clk);
    check("R10 no mdc", 64'(rise_total - rt), 64'd0);

    run_txn(1'b1, 5'h01, 5'h1F, 3'd0, 16'hA55A, 16'h0, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h00, 3'd2, 16'h0, 16'hC3E1, 1'b0);
    run_txn(1'b1, 5'h0C, 5'h13, 3'd1, 16'h8001, 16'h0, 1'b1);
    run_txn(1'b0, 5'h00, 5'h1F, 3'd6, 16'h0, 16'h0001, 1'b0);
    run_txn(1'b0, 5'h11, 5'h05, 3'd0, 16'h0, 16'hFFFF, 1'b1);

    for (int i = 0; i < 8; i++) begin
      logic wr_r;
      logic [2:0] sel_r;
      wr_r  = 1'($urandom);
      sel_r = 3'($urandom);
      run_txn(wr_r, 5'($urandom), 5'($urandom), sel_r, 16'($urandom), 16'($urandom), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule